// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block holds an 8-bit accumulator together with its carry, auxiliary carry, overflow and parity flags. Each cycle with `en` high, it performs one operation chosen by `op`. The operation uses the accumulator, an 8-bit operand and a single `bit_in` value. The operand has already been fetched by the surrounding datapath from a register, a direct or indirect location, or an immediate field. Results land in the accumulator and flags at the next clock edge.

Some operations target the operand's storage location rather than the accumulator. These are exchanges, increment and decrement of a location, and logic ops into a location. For them the block presents the new value combinationally on `dest` and raises `dest_we` in the same cycle. The caller writes that value back at the edge.

The parity flag is a register that follows the accumulator. After any edge, it matches whatever value the accumulator took at that edge.

Top module: `acc_alu`

## Requirements
- R1: After reset, the accumulator, C (`cy`), AC (`ac`), OV (`ov`) and P (`par`) are all 0.
- R2: Op 2 (add) sets A to A+operand. Op 3 (add with carry) sets A to A+operand+C. Both set C to the carry out of bit 7, AC to the carry out of bit 3, and OV to signed overflow of the 8-bit result.
- R3: Op 4 (subtract with borrow) sets A to A−operand−C. C becomes the borrow out of bit 7, AC the borrow out of bit 3, and OV signed overflow. No subtract form exists without the borrow.
- R4: Op 5 (AND), op 6 (OR) and op 7 (XOR) combine the operand into A and leave C, AC and OV unchanged.
- R5: Op 21 (AND), op 22 (OR) and op 23 (XOR) put operand∘A on `dest` with `dest_we`=1. A, C, AC and OV stay unchanged.
- R6: Op 8 increments A and op 9 decrements it, wrapping modulo 256 without touching C, AC or OV. Op 19 puts operand+1 on `dest` and op 20 puts operand−1 there, both with `dest_we`=1.
- R7: Op 1 loads the operand into A, op 10 clears A and op 11 complements A. None of them changes C, AC or OV.
- R8: Op 12 rotates A left and op 14 rotates it right, with no effect on C. Op 13 rotates left through C: the new bit 0 is the old C and the new C is the old bit 7. Op 15 rotates right through C: the new bit 7 is the old C and the new C is the old bit 0.
- R9: Op 16 exchanges the high and low nibbles of A.
- R10: Op 17 loads the operand into A and presents the old A on `dest` with `dest_we`=1.
- R11: Op 18 swaps bits 3..0 of A with bits 3..0 of the operand. `dest` is {operand[7:4], A[3:0]}, and both upper nibbles are kept.
- R12: Carry logic works on C alone, with A unchanged. Op 24 gives C AND bit_in, op 25 gives C AND NOT bit_in, op 26 gives C OR bit_in, op 27 sets C, op 28 clears C and op 29 complements C.
- R13: After every edge out of reset, P equals the XOR of all eight accumulator bits (even parity).
- R14: With `en` low, or with op 0, 30 or 31, A and all flags hold and `dest_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Execute the selected operation this cycle |
| op | input | 5 | Operation select |
| opnd | input | 8 | Fetched operand |
| bit_in | input | 1 | Addressed bit for carry logic |
| acc | output | 8 | Accumulator |
| cy | output | 1 | Carry flag C |
| ac | output | 1 | Auxiliary carry AC |
| ov | output | 1 | Overflow OV |
| par | output | 1 | Parity flag P |
| dest | output | 8 | Value for the operand's location |
| dest_we | output | 1 | `dest` is to be written this cycle |

## Verification
Directed pairs target the arithmetic boundaries, and each pair separates a different flag source.
- 0x7F+0x01 raises AC and OV without C.
- 0xFF+0x01 raises C and AC without OV.
- 0x00−0x01 borrows from both bit 3 and bit 7.
- 0x80−0x01 overflows with no borrow.

A seeded random stream then covers all 32 op codes with arbitrary operands, carry states and idle cycles. This stream separates a flag taken from the wrong carry stage, an op that disturbs flags it must keep, and a wrong nibble or rotate direction.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [4:0] op,
  input  logic [7:0] opnd,
  input  logic       bit_in,
  output logic [7:0] acc,
  output logic       cy,
  output logic       ac,
  output logic       ov,
  output logic       par,
  output logic [7:0] dest,
  output logic       dest_we
);
  localparam logic [4:0] OP_LDA  = 5'd1,  OP_ADD  = 5'd2,  OP_ADDC = 5'd3,  OP_SUBB = 5'd4;
  localparam logic [4:0] OP_ANL  = 5'd5,  OP_ORL  = 5'd6,  OP_XRL  = 5'd7,  OP_INCA = 5'd8;
  localparam logic [4:0] OP_DECA = 5'd9,  OP_CLRA = 5'd10, OP_CPLA = 5'd11, OP_RL   = 5'd12;
  localparam logic [4:0] OP_RLC  = 5'd13, OP_RR   = 5'd14, OP_RRC  = 5'd15, OP_SWAP = 5'd16;
  localparam logic [4:0] OP_XCH  = 5'd17, OP_XCHD = 5'd18, OP_INCM = 5'd19, OP_DECM = 5'd20;
  localparam logic [4:0] OP_ANLM = 5'd21, OP_ORLM = 5'd22, OP_XRLM = 5'd23, OP_CANL = 5'd24;
  localparam logic [4:0] OP_CANN = 5'd25, OP_CORL = 5'd26, OP_SETC = 5'd27, OP_CLRC = 5'd28;
  localparam logic [4:0] OP_CPLC = 5'd29;

  logic       is_sub;
  logic [7:0] b;
  logic       cin;
  logic [4:0] lo;
  logic [7:0] lo7;
  logic [8:0] sum;
  logic [7:0] acc_n;
  logic       cy_n, ac_n, ov_n, wr;

  assign is_sub = (op == OP_SUBB);
  assign b      = is_sub ? ~opnd : opnd;
  assign cin    = is_sub ? ~cy : ((op == OP_ADDC) & cy);
  assign lo     = {1'b0, acc[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
  assign lo7    = {1'b0, acc[6:0]} + {1'b0, b[6:0]} + {7'd0, cin};
  assign sum    = {1'b0, acc} + {1'b0, b} + {8'd0, cin};
  assign dest_we = en & wr;

  always_comb begin
    acc_n = acc;
    cy_n  = cy;
    ac_n  = ac;
    ov_n  = ov;
    dest  = opnd;
    wr    = 1'b0;
    case (op)
      OP_LDA:  acc_n = opnd;
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_n = sum[7:0];
        cy_n  = sum[8] ^ is_sub;
        ac_n  = lo[4] ^ is_sub;
        ov_n  = lo7[7] ^ sum[8];
      end
      OP_ANL:  acc_n = acc & opnd;
      OP_ORL:  acc_n = acc | opnd;
      OP_XRL:  acc_n = acc ^ opnd;
      OP_INCA: acc_n = acc + 8'd1;
      OP_DECA: acc_n = acc - 8'd1;
      OP_CLRA: acc_n = 8'd0;
      OP_CPLA: acc_n = ~acc;
      OP_RL:   acc_n = {acc[6:0], acc[7]};
      OP_RLC:  begin acc_n = {acc[6:0], cy}; cy_n = acc[7]; end
      OP_RR:   acc_n = {acc[0], acc[7:1]};
      OP_RRC:  begin acc_n = {cy, acc[7:1]}; cy_n = acc[0]; end
      OP_SWAP: acc_n = {acc[3:0], acc[7:4]};
      OP_XCH:  begin acc_n = opnd; dest = acc; wr = 1'b1; end
      OP_XCHD: begin acc_n = {acc[7:4], opnd[3:0]}; dest = {opnd[7:4], acc[3:0]}; wr = 1'b1; end
      OP_INCM: begin dest = opnd + 8'd1; wr = 1'b1; end
      OP_DECM: begin dest = opnd - 8'd1; wr = 1'b1; end
      OP_ANLM: begin dest = opnd & acc; wr = 1'b1; end
      OP_ORLM: begin dest = opnd | acc; wr = 1'b1; end
      OP_XRLM: begin dest = opnd ^ acc; wr = 1'b1; end
      OP_CANL: cy_n = cy & bit_in;
      OP_CANN: cy_n = cy & ~bit_in;
      OP_CORL: cy_n = cy | bit_in;
      OP_SETC: cy_n = 1'b1;
      OP_CLRC: cy_n = 1'b0;
      OP_CPLC: cy_n = ~cy;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= 8'd0;
      cy  <= 1'b0;
      ac  <= 1'b0;
      ov  <= 1'b0;
      par <= 1'b0;
    end else if (en) begin
      acc <= acc_n;
      cy  <= cy_n;
      ac  <= ac_n;
      ov  <= ov_n;
      par <= ^acc_n;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [4:0] op,
  input logic [7:0] opnd,
  input logic [7:0] acc,
  input logic       cy,
  input logic       ac,
  input logic       ov,
  input logic       par,
  input logic       dest_we
);
  // R13
  parity_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> par == ^acc);

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc) && $stable(cy) && $stable(ac) && $stable(ov));

  // R14
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !dest_we);

  // R4
  logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == 5'd5 || op == 5'd6 || op == 5'd7) |=> $stable(cy) && $stable(ac) && $stable(ov));

  // R10
  xch_loads_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd17 |=> acc == $past(opnd));

  // R12
  setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd27 |=> cy && $stable(acc));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opnd(opnd), .acc(acc),
  .cy(cy), .ac(ac), .ov(ov), .par(par), .dest_we(dest_we)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] opnd = 8'd0;
  logic       bit_in = 1'b0;
  logic [7:0] acc, dest;
  logic       cy, ac, ov, par, dest_we;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_acc = 8'd0;
  logic       m_cy = 1'b0, m_ac = 1'b0, m_ov = 1'b0;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opnd(opnd), .bit_in(bit_in),
    .acc(acc), .cy(cy), .ac(ac), .ov(ov), .par(par), .dest(dest), .dest_we(dest_we)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sgn(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic step(input int o, input logic [7:0] d, input logic bv, input logic e);
    logic [7:0] na = m_acc;
    logic ncy = m_cy, nac = m_ac, nov = m_ov;
    logic [7:0] ed = d;
    logic ewe = 1'b0;
    string rq = "R14";
    int s, c, sr;
    @(negedge clk);
    en = e; op = o[4:0]; opnd = d; bit_in = bv;
    if (e) begin
      case (o)
        1:  begin na = d; rq = "R7"; end
        2, 3: begin
          c = (o == 3) ? int'(m_cy) : 0;
          s = int'(m_acc) + int'(d) + c;
          na = s[7:0]; ncy = s > 255;
          nac = (int'(m_acc % 16) + int'(d % 16) + c) > 15;
          sr = sgn(m_acc) + sgn(d) + c; nov = (sr > 127) || (sr < -128);
          rq = "R2";
        end
        4: begin
          c = int'(m_cy);
          s = int'(m_acc) - int'(d) - c;
          na = s[7:0]; ncy = s < 0;
          nac = (int'(m_acc % 16) - int'(d % 16) - c) < 0;
          sr = sgn(m_acc) - sgn(d) - c; nov = (sr > 127) || (sr < -128);
          rq = "R3";
        end
        5:  begin na = m_acc & d; rq = "R4"; end
        6:  begin na = m_acc | d; rq = "R4"; end
        7:  begin na = m_acc ^ d; rq = "R4"; end
        8:  begin na = m_acc + 8'd1; rq = "R6"; end
        9:  begin na = m_acc - 8'd1; rq = "R6"; end
        10: begin na = 8'd0; rq = "R7"; end
        11: begin na = ~m_acc; rq = "R7"; end
        12: begin na = (m_acc << 1) | (m_acc >> 7); rq = "R8"; end
        13: begin na = (m_acc << 1) | 8'(m_cy); ncy = m_acc[7]; rq = "R8"; end
        14: begin na = (m_acc >> 1) | (m_acc << 7); rq = "R8"; end
        15: begin na = (m_acc >> 1) | (m_cy ? 8'h80 : 8'h00); ncy = m_acc[0]; rq = "R8"; end
        16: begin na = (m_acc << 4) | (m_acc >> 4); rq = "R9"; end
        17: begin na = d; ed = m_acc; ewe = 1'b1; rq = "R10"; end
        18: begin na = (m_acc & 8'hF0) | (d & 8'h0F); ed = (d & 8'hF0) | (m_acc & 8'h0F); ewe = 1'b1; rq = "R11"; end
        19: begin ed = d + 8'd1; ewe = 1'b1; rq = "R6"; end
        20: begin ed = d - 8'd1; ewe = 1'b1; rq = "R6"; end
        21: begin ed = d & m_acc; ewe = 1'b1; rq = "R5"; end
        22: begin ed = d | m_acc; ewe = 1'b1; rq = "R5"; end
        23: begin ed = d ^ m_acc; ewe = 1'b1; rq = "R5"; end
        24: begin ncy = m_cy && bv; rq = "R12"; end
        25: begin ncy = m_cy && !bv; rq = "R12"; end
        26: begin ncy = m_cy || bv; rq = "R12"; end
        27: begin ncy = 1'b1; rq = "R12"; end
        28: begin ncy = 1'b0; rq = "R12"; end
        29: begin ncy = !m_cy; rq = "R12"; end
        default: rq = "R14";
      endcase
    end
    #1;
    chk(rq, "dest_we", int'(dest_we), int'(ewe));
    if (ewe) chk(rq, "dest", int'(dest), int'(ed));
    @(posedge clk); #1;
    chk(rq, "acc", int'(acc), int'(na));
    chk(rq, "cy", int'(cy), int'(ncy));
    chk(rq, "ac", int'(ac), int'(nac));
    chk(rq, "ov", int'(ov), int'(nov));
    chk("R13", "par", int'(par), int'(^na));
    m_acc = na; m_cy = ncy; m_ac = nac; m_ov = nov;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "acc", int'(acc), 0);
    chk("R1", "cy", int'(cy), 0);
    chk("R1", "ac", int'(ac), 0);
    chk("R1", "ov", int'(ov), 0);
    chk("R1", "par", int'(par), 0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 8'h7F, 0, 1); step(2, 8'h01, 0, 1);       // R2: AC and OV, no C
    step(1, 8'hFF, 0, 1); step(2, 8'h01, 0, 1);       // R2: C and AC, no OV
    step(28, 8'h00, 0, 1); step(1, 8'h00, 0, 1);
    step(4, 8'h01, 0, 1);                             // R3: 0-1 borrows
    step(28, 8'h00, 0, 1); step(1, 8'h80, 0, 1);
    step(4, 8'h01, 0, 1);                             // R3: signed overflow
    step(27, 8'h00, 0, 1); step(1, 8'h10, 0, 1);
    step(4, 8'h10, 0, 1);                             // R3: borrow included
    step(27, 8'h00, 0, 1); step(3, 8'h0F, 0, 1);      // R2: carry in
    step(5, 8'h0F, 0, 1); step(6, 8'hA0, 0, 1); step(7, 8'hFF, 0, 1); // R4
    step(1, 8'h5A, 0, 1); step(18, 8'hC3, 0, 1);      // R11
    step(17, 8'h81, 0, 1); step(16, 8'h00, 0, 1);     // R10, R9
    step(13, 8'h00, 0, 1); step(15, 8'h00, 0, 1);     // R8
    step(1, 8'hFF, 0, 1); step(8, 8'h00, 0, 1); step(9, 8'h00, 0, 1); // R6 wrap
    step(19, 8'hFF, 0, 1); step(20, 8'h00, 0, 1);     // R6
    step(21, 8'h3C, 0, 1);                            // R5
    step(2, 8'h55, 0, 0); step(31, 8'h55, 0, 1);      // R14
    step(27, 8'h00, 0, 1); step(25, 8'h00, 1, 1); step(26, 8'h00, 1, 1); // R12

    for (int i = 0; i < 600; i++) begin
      int o = int'($urandom % 32);
      logic [7:0] d = 8'($urandom);
      logic bv = 1'($urandom);
      logic e = ($urandom % 8) != 0;
      step(o, d, bv, e);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule